// File: doc/BRIEF.md
# Fixed-Period PWM Generator

This block turns an 8-bit width code into a repeating pulse train on one output pin, clocked by a single system clock. Every period is exactly 255 clocks long. The output is high for `width` of those clocks, so the duty fraction is width/255. A code of 0 holds the pin low and a code of 255 holds it high, with no stray edge in either case. The block has no clock divider. It has no bus interface either: the system clock and the width code drive it directly, and both inputs are taken as already synchronous to that clock.

The width code is captured only at the start of each period. A new code written partway through a period therefore cannot shorten a pulse or add one. A synchronous active-high reset forces the pin low. The first full period begins on the first clock edge after reset is released, and the width is captured on that same edge.

Top module: `pwm_fixed_gen`

## Requirements
- R1: The output waveform repeats with a period of exactly 255 clock cycles. Cycle positions 0 to 254 follow one another, and position 0 follows 254.
- R2: In cycle position k of a period, the output is high exactly when k is less than the width captured for that period. The output is therefore high for the first `width` cycles and low for the rest.
- R3: A captured width of 0 holds the output low in every cycle of the period.
- R4: A captured width of 255 holds the output high in every cycle of the period, including when one such period follows another.
- R5: A change of the width input at any position other than the period start has no effect on the current period. The new value takes effect only from the next period start.
- R6: While the synchronous reset input is 1, the output is 0 after each rising edge, whatever the width input is.
- R7: On the first rising edge with reset at 0, the block enters cycle position 0 and captures the width input. The output is then high after that edge if the captured width is greater than 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| width | input | 8 | Duty code, unsigned; high time in clocks per 255-clock period |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Every result of this block appears one rising edge after the edge that decides it. The output after the edge that enters position k reflects k and the width captured at the period start. The bench drives inputs on the falling edge and samples one time unit after each rising edge, so each sample sees exactly the edge it is predicted for. The expected level is worked out from the position count that the bench keeps itself and the width it wrote at the period start. All 256 width codes are swept. In every period the width input is scrambled on falling edges after the start, which tests that mid-period changes are ignored. A mid-period reset and a restart are also checked.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    // Width of the duty code; the period is (2**DUTY_W - 1) clocks.
    localparam int DUTY_W     = 8;
    localparam int PERIOD     = (1 << DUTY_W) - 1;
    localparam int LAST_POS   = PERIOD - 1;

    typedef logic [DUTY_W-1:0] duty_t;

    // Period-counter state: position in period plus a flag that is clear
    // until the first edge out of reset.
    typedef struct packed {
        duty_t pos;
        logic  running;
    } ctr_state_t;

    // Advance the position; wraps from LAST_POS back to zero.
    function automatic duty_t next_pos(input duty_t p, input logic restart);
        if (restart || p == duty_t'(LAST_POS))
            return '0;
        return p + duty_t'(1);
    endfunction

    // Output level for a position against a captured width.
    function automatic logic level_for(input duty_t p, input duty_t w);
        return p < w;
    endfunction
endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output duty_t pos_q,
    output duty_t pos_next,
    output logic  running_q,
    output logic  period_start
);
    ctr_state_t st_q;
    ctr_state_t st_d;

    always_comb begin
        period_start = !st_q.running || (st_q.pos == duty_t'(LAST_POS));
        st_d.pos     = next_pos(st_q.pos, !st_q.running);
        st_d.running = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_q     = st_q.pos;
    assign pos_next  = st_d.pos;
    assign running_q = st_q.running;

    // R1: position never exceeds the last slot of the period
    p_pos_range_r1: assert property (@(posedge clk) disable iff (rst)
        pos_q <= duty_t'(LAST_POS));

    // R1: after the last slot the next position is zero
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (running_q && pos_q == duty_t'(LAST_POS)) |=> (pos_q == '0));
endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch
    import pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  duty_t width_in,
    output duty_t duty_q,
    output duty_t duty_next
);
    always_comb begin
        duty_next = load ? width_in : duty_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_q <= '0;
        end else begin
            duty_q <= duty_next;
        end
    end
endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out
    import pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  duty_t pos_next,
    input  duty_t duty_next,
    output logic  pwm_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= level_for(pos_next, duty_next);
        end
    end
endmodule

// File: rtl/pwm_fixed_gen.sv
module pwm_fixed_gen
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] width,
    output logic              pwm_out
);
    duty_t pos_q;
    duty_t pos_next;
    duty_t duty_q;
    duty_t duty_next;
    logic  running_q;
    logic  period_start;

    pwm_period_ctr u_ctr (
        .clk          (clk),
        .rst          (rst),
        .pos_q        (pos_q),
        .pos_next     (pos_next),
        .running_q    (running_q),
        .period_start (period_start)
    );

    pwm_duty_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (period_start),
        .width_in  (width),
        .duty_q    (duty_q),
        .duty_next (duty_next)
    );

    pwm_compare_out u_cmp (
        .clk       (clk),
        .rst       (rst),
        .pos_next  (pos_next),
        .duty_next (duty_next),
        .pwm_q     (pwm_out)
    );

    // R5: captured width only moves on the edge that enters position 0
    p_duty_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (pos_q != '0) |-> $stable(duty_q));

    // R3: a zero width keeps the pin low
    p_zero_low_r3: assert property (@(posedge clk) disable iff (rst)
        (duty_q == '0) |-> !pwm_out);

    // R4: a full width keeps the pin high once running
    p_full_high_r4: assert property (@(posedge clk) disable iff (rst)
        (running_q && duty_q == duty_t'(PERIOD)) |-> pwm_out);

    // R2: pin agrees with position versus captured width
    p_level_r2: assert property (@(posedge clk) disable iff (rst)
        running_q |-> (pwm_out == (pos_q < duty_q)));
endmodule

// File: tb/pwm_fixed_gen_bench.sv
`timescale 1ns/1ps
module pwm_fixed_gen_bench;
    localparam int PER = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] width = 8'd0;
    logic       pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pwm_fixed_gen u_pwm_fixed_gen (
        .clk     (clk),
        .rst     (rst),
        .width   (width),
        .pwm_out (pwm_out)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: pwm_out=%b expected %b at t=%0t", tag, got, exp, $time);
        end
    endtask

    // Runs one period with captured width w (already on the input before the
    // start edge); scrambles the input mid-period, presents nxt before the end.
    task automatic run_period(input int w, input int nxt, input bit first);
        int highs = 0;
        for (int k = 0; k < PER; k++) begin
            @(posedge clk); #1;
            if (first && k == 0)      check(pwm_out, w > 0, "R7");
            else if (w == 0)          check(pwm_out, 1'b0, "R3");
            else if (w == 255)        check(pwm_out, 1'b1, "R4");
            else if (k > 0)           check(pwm_out, k < w, "R5");
            else                      check(pwm_out, k < w, "R2");
            if (pwm_out) highs++;
            @(negedge clk);
            if (k == PER - 1) width = 8'(nxt);
            else              width = 8'((w * 37 + k * 11 + 5) & 255);
        end
        check(highs == w, 1'b1, "R1");
    endtask

    initial begin
        // R6: reset holds the pin low whatever the width
        width = 8'd255;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            check(pwm_out, 1'b0, "R6");
            @(negedge clk);
            width = 8'(i * 90 + 1);
        end
        width = 8'd0;
        rst   = 1'b0;
        for (int w = 0; w < 256; w++) begin
            run_period(w, (w == 255) ? 255 : w + 1, w == 0);
        end
        // R4: back-to-back full periods
        run_period(255, 100, 1'b0);
        run_period(100, 200, 1'b0);
        // Mid-period reset then restart
        for (int k = 0; k < 50; k++) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        check(pwm_out, 1'b0, "R6");
        @(posedge clk); #1;
        check(pwm_out, 1'b0, "R6");
        @(negedge clk);
        rst   = 1'b0;
        width = 8'd1;
        run_period(1, 0, 1'b1);
        run_period(0, 0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not finish, got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule